// File: doc/BRIEF.md
# Flash Command Sequence Decoder

This block sits between a host bus and a flash write state machine. Each host write cycle presents an address and a data word. The block tracks these writes through multi-cycle unlock sequences and turns a completed sequence into one of three things: a change of read path (array, identifier or status), a clear-status pulse, or a start pulse for page program, chip erase, sector erase, sector protect, sector unprotect or abort. Commands that address a sector also latch the sector number for the write state machine.

Two conditions limit which commands are acted on. While the write state machine reports busy, only the status-read and abort commands take effect. While a fault is pending, program and erase starts are refused.

The block also supplies the identifier read word. This word carries the manufacturer code, the device code and the per-sector protect query for the two protectable sectors.

Top module: `flash_cmd_decoder`

## Requirements
- R1: A command opens with data AAh at address 5555h and then data 55h at address 2AAAh. Only address bits 14..0 are compared and only data bits 7..0 are decoded.
- R2: After the opening pair, a third write at 5555h selects the read path or a pulse. The read path is encoded on rd_sel_o as 0 array, 1 identifier, 2 status. F0h selects array (0). 90h selects identifier (1). 70h selects status (2). 50h pulses clr_status_o and leaves the read path unchanged. E0h pulses abort_o and selects status. A0h pulses prog_start_o and selects status.
- R3: Erase takes six writes: the opening pair, 80h at 5555h, a second opening pair, then a final byte. A final 10h at 5555h pulses chip_erase_o. A final 30h at any address pulses sect_erase_o and latches address bits 19..15 into sector_o.
- R4: Protect takes six writes: the opening pair, 60h at 5555h, a second opening pair, then 20h or 40h at a sector address. 20h pulses prot_start_o and 40h pulses unprot_start_o, and either one latches the sector into sector_o.
- R5: Protect and unprotect are accepted only for sector 00000b or 11111b. For any other sector there is no pulse, and both sector_o and the read path are unchanged.
- R6: Any write that does not match the expected address and data for the current step returns the decoder to its start step with no pulse. The next command must begin again with AAh at 5555h.
- R7: While busy_i is high on a write, only 70h and E0h are acted on. All other commands, including the 80h and 60h set-up bytes and any final byte, are ignored.
- R8: While fault_i is high on the final write, page program, chip erase and sector erase are refused. Protect, unprotect, clear and read commands still act.
- R9: Every start of program, erase, protect, unprotect or abort sets the read path to status. The read path then stays there until a new valid read-selecting command arrives.
- R10: After reset rd_sel_o is 0 (array), sector_o is 0 and no pulse is active.
- R11: id_data_o depends on rd_addr_i[1:0], with all bits above 7 zero: 00 gives C2h, 01 gives the device code F6h, 10 gives C2h if the sector in rd_addr_i[19:15] is protected and 00h otherwise, and 11 gives 00h. prot_state_i bit 0 marks sector 0 protected and bit 1 marks sector 31 protected.
- R12: Each pulse is high for exactly one clock, the clock after the edge that samples the final write. At most one pulse is high at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | One-cycle host write strobe |
| wr_addr_i | input | 20 | Write address |
| wr_data_i | input | 16 | Write data; low byte decoded |
| busy_i | input | 1 | Write state machine busy |
| fault_i | input | 1 | Program or erase fault pending |
| rd_addr_i | input | 20 | Read address for identifier word |
| prot_state_i | input | 2 | Protect bits: bit 0 sector 0, bit 1 sector 31 |
| rd_sel_o | output | 2 | Read path: 0 array, 1 identifier, 2 status |
| id_data_o | output | 16 | Identifier read word |
| prog_start_o | output | 1 | Page program start pulse |
| chip_erase_o | output | 1 | Chip erase start pulse |
| sect_erase_o | output | 1 | Sector erase start pulse |
| prot_start_o | output | 1 | Sector protect start pulse |
| unprot_start_o | output | 1 | Sector unprotect start pulse |
| abort_o | output | 1 | Abort pulse |
| clr_status_o | output | 1 | Clear status pulse |
| sector_o | output | 5 | Latched sector number |

## Verification
Two events can fall in the same cycle: the final write of a six-write sequence and the write state machine reporting busy (or a fault pending). The bench provokes this by raising busy_i just before the sixth write of a sector erase, and fault_i across program, erase and protect sequences. A behavioural model keeps the writes of the current sequence in a queue and judges each completed sequence using the busy and fault values sampled at that same edge. On every clock it compares all pulses, the read path and the sector against the design. Abort and status read issued while busy are judged the same way and must still act.

// File: rtl/fcd_pkg.sv
`timescale 1ns/1ps
package fcd_pkg;
  typedef enum logic [1:0] {RD_ARRAY = 2'd0, RD_IDENT = 2'd1, RD_STATUS = 2'd2} rd_sel_e;

  typedef enum logic [3:0] {
    OP_NONE = 4'd0, OP_RD_ARRAY, OP_RD_IDENT, OP_RD_STATUS, OP_CLEAR, OP_ABORT,
    OP_PROG, OP_CHIP_ERASE, OP_SECT_ERASE, OP_PROT, OP_UNPROT
  } op_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_UNL1, ST_UNL2, ST_SET, ST_SET_UNL1, ST_SET_UNL2
  } step_e;

  localparam logic [14:0] ADDR_KEY_A = 15'h5555;
  localparam logic [14:0] ADDR_KEY_B = 15'h2AAA;

  localparam logic [7:0] BYTE_UNL_A    = 8'hAA;
  localparam logic [7:0] BYTE_UNL_B    = 8'h55;
  localparam logic [7:0] BYTE_RD_ARRAY = 8'hF0;
  localparam logic [7:0] BYTE_RD_IDENT = 8'h90;
  localparam logic [7:0] BYTE_RD_STAT  = 8'h70;
  localparam logic [7:0] BYTE_CLEAR    = 8'h50;
  localparam logic [7:0] BYTE_ABORT    = 8'hE0;
  localparam logic [7:0] BYTE_PROG     = 8'hA0;
  localparam logic [7:0] BYTE_ERASE_SU = 8'h80;
  localparam logic [7:0] BYTE_PROT_SU  = 8'h60;
  localparam logic [7:0] BYTE_CHIP     = 8'h10;
  localparam logic [7:0] BYTE_SECT     = 8'h30;
  localparam logic [7:0] BYTE_LOCK     = 8'h20;
  localparam logic [7:0] BYTE_UNLOCK   = 8'h40;

  localparam int N_PULSE  = 7;
  localparam int P_CLEAR  = 0;
  localparam int P_ABORT  = 1;
  localparam int P_PROG   = 2;
  localparam int P_CHIP   = 3;
  localparam int P_SECT   = 4;
  localparam int P_PROT   = 5;
  localparam int P_UNPROT = 6;

  localparam op_e PULSE_OP [N_PULSE] = '{
    OP_CLEAR, OP_ABORT, OP_PROG, OP_CHIP_ERASE, OP_SECT_ERASE, OP_PROT, OP_UNPROT
  };
endpackage

// File: rtl/fcd_addr_match.sv
`timescale 1ns/1ps
module fcd_addr_match #(
  parameter int            AW  = 15,
  parameter logic [AW-1:0] KEY = '0
) (
  input  logic [AW-1:0] addr_i,
  output logic          hit_o
);
  assign hit_o = (addr_i == KEY);
endmodule

// File: rtl/fcd_seq.sv
`timescale 1ns/1ps
module fcd_seq
  import fcd_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wr_en_i,
  input  logic [7:0] byte_i,
  input  logic       at_a_i,
  input  logic       at_b_i,
  input  logic       prot_ok_i,
  input  logic       busy_i,
  input  logic       fault_i,
  output op_e        op_o
);
  step_e step_q, step_d;
  logic  kind_q, kind_d; // 0 erase set-up, 1 protect set-up

  logic unl_a, unl_b;
  assign unl_a = at_a_i && (byte_i == BYTE_UNL_A);
  assign unl_b = at_b_i && (byte_i == BYTE_UNL_B);

  always_comb begin
    step_d = step_q;
    kind_d = kind_q;
    op_o   = OP_NONE;
    if (wr_en_i) begin
      step_d = ST_IDLE;
      unique case (step_q)
        ST_IDLE:     if (unl_a) step_d = ST_UNL1;
        ST_UNL1:     if (unl_b) step_d = ST_UNL2;
        ST_UNL2: begin
          if (at_a_i) begin
            case (byte_i)
              BYTE_RD_ARRAY: if (!busy_i) op_o = OP_RD_ARRAY;
              BYTE_RD_IDENT: if (!busy_i) op_o = OP_RD_IDENT;
              BYTE_RD_STAT:  op_o = OP_RD_STATUS;
              BYTE_ABORT:    op_o = OP_ABORT;
              BYTE_CLEAR:    if (!busy_i) op_o = OP_CLEAR;
              BYTE_PROG:     if (!busy_i && !fault_i) op_o = OP_PROG;
              BYTE_ERASE_SU: if (!busy_i) begin step_d = ST_SET; kind_d = 1'b0; end
              BYTE_PROT_SU:  if (!busy_i) begin step_d = ST_SET; kind_d = 1'b1; end
              default: ;
            endcase
          end
        end
        ST_SET:      if (unl_a) step_d = ST_SET_UNL1;
        ST_SET_UNL1: if (unl_b) step_d = ST_SET_UNL2;
        ST_SET_UNL2: begin
          if (!busy_i) begin
            if (!kind_q) begin
              if (!fault_i && at_a_i && byte_i == BYTE_CHIP) op_o = OP_CHIP_ERASE;
              else if (!fault_i && byte_i == BYTE_SECT)      op_o = OP_SECT_ERASE;
            end else if (prot_ok_i) begin
              if (byte_i == BYTE_LOCK)        op_o = OP_PROT;
              else if (byte_i == BYTE_UNLOCK) op_o = OP_UNPROT;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      step_q <= ST_IDLE;
      kind_q <= 1'b0;
    end else begin
      step_q <= step_d;
      kind_q <= kind_d;
    end
  end

  AST_OPEN_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && step_q == ST_IDLE) |=> (step_q == ST_IDLE || step_q == ST_UNL1)); // R1
  AST_BAD_SECOND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && step_q == ST_UNL1 && !(at_b_i && byte_i == BYTE_UNL_B)) |=> step_q == ST_IDLE); // R6
  AST_FINAL_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && step_q == ST_SET_UNL2) |=> step_q == ST_IDLE); // R6
endmodule

// File: rtl/fcd_issue.sv
`timescale 1ns/1ps
module fcd_issue
  import fcd_pkg::*;
#(
  parameter int SECT_W = 5
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  op_e                op_i,
  input  logic [SECT_W-1:0]  sector_i,
  output logic [N_PULSE-1:0] pulse_o,
  output rd_sel_e            rd_sel_o,
  output logic [SECT_W-1:0]  sector_o
);
  logic [N_PULSE-1:0] hit;
  logic [N_PULSE-1:0] pulse_q;
  rd_sel_e            rd_q, rd_d;
  logic [SECT_W-1:0]  sector_q;

  for (genvar i = 0; i < N_PULSE; i++) begin : g_hit
    assign hit[i] = (op_i == PULSE_OP[i]);
  end

  always_comb begin
    rd_d = rd_q;
    case (op_i)
      OP_RD_ARRAY:       rd_d = RD_ARRAY;
      OP_RD_IDENT:       rd_d = RD_IDENT;
      OP_NONE, OP_CLEAR: ;
      default:           rd_d = RD_STATUS;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pulse_q  <= '0;
      rd_q     <= RD_ARRAY;
      sector_q <= '0;
    end else begin
      pulse_q <= hit;
      rd_q    <= rd_d;
      if (op_i inside {OP_SECT_ERASE, OP_PROT, OP_UNPROT}) sector_q <= sector_i;
    end
  end

  assign pulse_o  = pulse_q;
  assign rd_sel_o = rd_q;
  assign sector_o = sector_q;

  AST_ONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(pulse_q)); // R12
  AST_PULSE_SHORT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pulse_q != '0) |=> (pulse_q == '0)); // R12
endmodule

// File: rtl/fcd_id_mux.sv
`timescale 1ns/1ps
module fcd_id_mux #(
  parameter int         ADDR_W   = 20,
  parameter int         DATA_W   = 16,
  parameter int         SECT_W   = 5,
  parameter logic [7:0] MFR_CODE = 8'hC2,
  parameter logic [7:0] DEV_CODE = 8'hF6
) (
  input  logic [ADDR_W-1:0] rd_addr_i,
  input  logic [1:0]        prot_state_i,
  output logic [DATA_W-1:0] data_o
);
  logic [SECT_W-1:0] sect;
  logic              is_prot;
  logic              unused_mid;

  assign sect       = rd_addr_i[ADDR_W-1 -: SECT_W];
  assign is_prot    = ((sect == '0) && prot_state_i[0]) || ((sect == '1) && prot_state_i[1]);
  assign unused_mid = ^rd_addr_i[ADDR_W-SECT_W-1:2];

  always_comb begin
    data_o = '0;
    unique case (rd_addr_i[1:0])
      2'b00:   data_o[7:0] = MFR_CODE;
      2'b01:   data_o[7:0] = DEV_CODE;
      2'b10:   data_o[7:0] = is_prot ? MFR_CODE : 8'h00;
      default: ;
    endcase
  end
endmodule

// File: rtl/flash_cmd_decoder.sv
`timescale 1ns/1ps
module flash_cmd_decoder
  import fcd_pkg::*;
#(
  parameter int         ADDR_W   = 20,
  parameter int         DATA_W   = 16,
  parameter int         SECT_W   = 5,
  parameter logic [7:0] MFR_CODE = 8'hC2,
  parameter logic [7:0] DEV_CODE = 8'hF6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              busy_i,
  input  logic              fault_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  input  logic [1:0]        prot_state_i,
  output logic [1:0]        rd_sel_o,
  output logic [DATA_W-1:0] id_data_o,
  output logic              prog_start_o,
  output logic              chip_erase_o,
  output logic              sect_erase_o,
  output logic              prot_start_o,
  output logic              unprot_start_o,
  output logic              abort_o,
  output logic              clr_status_o,
  output logic [SECT_W-1:0] sector_o
);
  localparam int CMD_AW = ADDR_W - SECT_W;
  localparam logic [CMD_AW-1:0] KEYS [2] = '{CMD_AW'(ADDR_KEY_A), CMD_AW'(ADDR_KEY_B)};

  logic [1:0]         key_hit;
  logic [SECT_W-1:0]  wr_sector;
  logic               prot_ok;
  logic               unused_hi;
  op_e                op;
  rd_sel_e            rd_sel;
  logic [N_PULSE-1:0] pulse;

  for (genvar g = 0; g < 2; g++) begin : g_key
    fcd_addr_match #(.AW(CMD_AW), .KEY(KEYS[g])) u_match (
      .addr_i (wr_addr_i[CMD_AW-1:0]),
      .hit_o  (key_hit[g])
    );
  end

  assign wr_sector = wr_addr_i[ADDR_W-1 -: SECT_W];
  assign prot_ok   = (wr_sector == '0) || (wr_sector == '1);
  assign unused_hi = ^wr_data_i[DATA_W-1:8];

  fcd_seq u_seq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .byte_i    (wr_data_i[7:0]),
    .at_a_i    (key_hit[0]),
    .at_b_i    (key_hit[1]),
    .prot_ok_i (prot_ok),
    .busy_i    (busy_i),
    .fault_i   (fault_i),
    .op_o      (op)
  );

  fcd_issue #(.SECT_W(SECT_W)) u_issue (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .op_i     (op),
    .sector_i (wr_sector),
    .pulse_o  (pulse),
    .rd_sel_o (rd_sel),
    .sector_o (sector_o)
  );

  fcd_id_mux #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SECT_W(SECT_W),
    .MFR_CODE(MFR_CODE), .DEV_CODE(DEV_CODE)
  ) u_id (
    .rd_addr_i    (rd_addr_i),
    .prot_state_i (prot_state_i),
    .data_o       (id_data_o)
  );

  assign rd_sel_o       = rd_sel;
  assign clr_status_o   = pulse[P_CLEAR];
  assign abort_o        = pulse[P_ABORT];
  assign prog_start_o   = pulse[P_PROG];
  assign chip_erase_o   = pulse[P_CHIP];
  assign sect_erase_o   = pulse[P_SECT];
  assign prot_start_o   = pulse[P_PROT];
  assign unprot_start_o = pulse[P_UNPROT];

  AST_BUSY_GATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && busy_i) |=> !(prog_start_o || chip_erase_o || sect_erase_o ||
                              prot_start_o || unprot_start_o || clr_status_o)); // R7
  AST_FAULT_GATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && fault_i) |=> !(prog_start_o || chip_erase_o || sect_erase_o)); // R8
  AST_START_STATUS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (prog_start_o || chip_erase_o || sect_erase_o || prot_start_o || unprot_start_o || abort_o)
      |-> rd_sel_o == RD_STATUS); // R9
  AST_PROT_EDGE_SECT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (prot_start_o || unprot_start_o) |-> (sector_o == '0 || sector_o == '1)); // R5
  AST_QUIET_NO_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> (pulse == '0)); // R12
endmodule

// File: tb/sim_flash_cmd_decoder.sv
`timescale 1ns/1ps
module sim_flash_cmd_decoder;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [19:0] wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic        busy = 1'b0;
  logic        fault = 1'b0;
  logic [19:0] rd_addr = '0;
  logic [1:0]  prot = '0;
  logic [1:0]  rd_sel;
  logic [15:0] id_data;
  logic        prog_s, chip_s, sect_s, prot_s, unprot_s, abort_s, clr_s;
  logic [4:0]  sector;

  always #10 clk = ~clk;

  flash_cmd_decoder u0 (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .busy_i(busy), .fault_i(fault), .rd_addr_i(rd_addr), .prot_state_i(prot),
    .rd_sel_o(rd_sel), .id_data_o(id_data), .prog_start_o(prog_s), .chip_erase_o(chip_s),
    .sect_erase_o(sect_s), .prot_start_o(prot_s), .unprot_start_o(unprot_s),
    .abort_o(abort_s), .clr_status_o(clr_s), .sector_o(sector)
  );

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  task automatic chk(string req, string what, int act, int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic int pulses();
    return {25'd0, unprot_s, prot_s, sect_s, chip_s, prog_s, abort_s, clr_s};
  endfunction

  // reference model: queue of writes in the sequence under way
  typedef struct packed { logic [19:0] a; logic [7:0] d; } wr_t;
  wr_t      hist[$];
  int       m_rd = 0;
  int       m_sect = 0;
  bit [6:0] m_pulse = '0;

  function automatic bit is_wr(wr_t w, logic [14:0] a, logic [7:0] d);
    return (w.a[14:0] == a) && (w.d == d);
  endfunction

  task automatic evaluate();
    int  n = hist.size();
    bit  keep = 1'b1;
    int  sec;
    if (!is_wr(hist[0], 15'h5555, 8'hAA)) keep = 1'b0;
    if (n >= 2 && !is_wr(hist[1], 15'h2AAA, 8'h55)) keep = 1'b0;
    if (keep && n == 3) begin
      keep = 1'b0;
      if (hist[2].a[14:0] == 15'h5555) begin
        case (hist[2].d)
          8'hF0: if (!busy) m_rd = 0;
          8'h90: if (!busy) m_rd = 1;
          8'h70: m_rd = 2;
          8'h50: if (!busy) m_pulse[0] = 1'b1;
          8'hE0: begin m_pulse[1] = 1'b1; m_rd = 2; end
          8'hA0: if (!busy && !fault) begin m_pulse[2] = 1'b1; m_rd = 2; end
          8'h80, 8'h60: keep = !busy;
          default: ;
        endcase
      end
    end
    if (keep && n == 4 && !is_wr(hist[3], 15'h5555, 8'hAA)) keep = 1'b0;
    if (keep && n == 5 && !is_wr(hist[4], 15'h2AAA, 8'h55)) keep = 1'b0;
    if (keep && n == 6) begin
      keep = 1'b0;
      sec = int'(hist[5].a[19:15]);
      if (!busy) begin
        if (hist[2].d == 8'h80) begin
          if (!fault && is_wr(hist[5], 15'h5555, 8'h10)) begin m_pulse[3] = 1'b1; m_rd = 2; end
          else if (!fault && hist[5].d == 8'h30) begin m_pulse[4] = 1'b1; m_rd = 2; m_sect = sec; end
        end else if (sec == 0 || sec == 31) begin
          if (hist[5].d == 8'h20) begin m_pulse[5] = 1'b1; m_rd = 2; m_sect = sec; end
          else if (hist[5].d == 8'h40) begin m_pulse[6] = 1'b1; m_rd = 2; m_sect = sec; end
        end
      end
    end
    if (!keep) hist.delete();
  endtask

  always @(posedge clk) begin
    m_pulse = '0;
    if (!rst_n) begin
      hist.delete();
      m_rd = 0;
      m_sect = 0;
    end else if (wr_en) begin
      hist.push_back(wr_t'{a: wr_addr, d: wr_data[7:0]});
      evaluate();
    end
  end

  string ptag [7] = '{"R2", "R2", "R2", "R3", "R3", "R4", "R4"};

  always @(negedge clk) begin
    if (!done) begin
      for (int i = 0; i < 7; i++) chk(ptag[i], $sformatf("model pulse bit %0d", i), int'(pulses() >> i) & 1, int'(m_pulse[i]));
      chk("R9", "model read path", int'(rd_sel), m_rd);
      chk("R3", "model sector", int'(sector), m_sect);
    end
  end

  task automatic wr(input logic [19:0] a, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic unlock();
    wr(20'h05555, 16'h00AA);
    wr(20'h02AAA, 16'h0055);
  endtask

  task automatic cmd3(input logic [7:0] d);
    unlock();
    wr(20'h05555, {8'h00, d});
  endtask

  task automatic cmd6(input logic [7:0] su, input logic [19:0] fa, input logic [7:0] fd);
    unlock();
    wr(20'h05555, {8'h00, su});
    unlock();
    wr(fa, {8'h00, fd});
  endtask

  task automatic id_chk(input logic [19:0] a, input logic [1:0] p, input int exp);
    rd_addr = a; prot = p;
    #1;
    chk("R11", $sformatf("id word at %0h prot %0d", a, p), int'(id_data), exp);
  endtask

  task automatic finish_run();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_run++; n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R10", "reset read path", int'(rd_sel), 0);
    chk("R10", "reset sector", int'(sector), 0);
    chk("R10", "reset pulses", pulses(), 0);
    rst_n = 1'b1;

    id_chk(20'h00000, 2'b00, 16'h00C2);
    id_chk(20'h00001, 2'b00, 16'h00F6);
    id_chk({5'd0, 13'h0, 2'b10}, 2'b01, 16'h00C2);
    id_chk({5'd0, 13'h0, 2'b10}, 2'b00, 16'h0000);
    id_chk({5'd31, 13'h5, 2'b10}, 2'b10, 16'h00C2);
    id_chk({5'd31, 13'h0, 2'b10}, 2'b01, 16'h0000);
    id_chk({5'd9, 13'h0, 2'b10}, 2'b11, 16'h0000);
    id_chk(20'h00003, 2'b11, 16'h0000);

    cmd3(8'h70); chk("R2", "status select", int'(rd_sel), 2);
    cmd3(8'h90); chk("R2", "ident select", int'(rd_sel), 1);
    cmd3(8'hF0); chk("R2", "array select", int'(rd_sel), 0);

    // upper address and data bits must not matter
    wr(20'hF5555, 16'h3CAA);
    wr(20'h7AAAA, 16'hFF55);
    wr(20'hA5555, 16'h77A0);
    chk("R1", "program with noisy upper bits", pulses(), 4);
    chk("R9", "status after program", int'(rd_sel), 2);
    @(negedge clk);
    chk("R12", "pulse one cycle", pulses(), 0);

    cmd6(8'h80, 20'h05555, 8'h10);
    chk("R3", "chip erase pulse", pulses(), 8);
    cmd6(8'h80, {5'd7, 15'h1234}, 8'h30);
    chk("R3", "sector erase pulse", pulses(), 16);
    chk("R3", "sector latched", int'(sector), 7);

    cmd3(8'hF0);
    cmd6(8'h60, {5'd0, 15'h0}, 8'h20);
    chk("R4", "protect pulse", pulses(), 32);
    chk("R4", "protect sector", int'(sector), 0);
    cmd6(8'h60, {5'd31, 15'h0}, 8'h40);
    chk("R4", "unprotect pulse", pulses(), 64);
    chk("R4", "unprotect sector", int'(sector), 31);

    cmd3(8'hF0);
    cmd6(8'h60, {5'd3, 15'h0}, 8'h20);
    chk("R5", "middle sector refused", pulses(), 0);
    chk("R5", "sector kept", int'(sector), 31);
    chk("R5", "read path kept", int'(rd_sel), 0);

    wr(20'h05555, 16'h00AA);
    wr(20'h01234, 16'h0055);
    wr(20'h02AAA, 16'h0055);
    wr(20'h05555, 16'h0070);
    chk("R6", "broken opening ignored", int'(rd_sel), 0);
    cmd3(8'h80);
    wr(20'h05555, 16'h00AA);
    wr(20'h02AAA, 16'h0000);
    wr(20'h05555, 16'h0010);
    chk("R6", "broken second pair ignored", pulses(), 0);

    busy = 1'b1;
    cmd3(8'h70); chk("R7", "status while busy", int'(rd_sel), 2);
    cmd3(8'hF0); chk("R7", "array refused while busy", int'(rd_sel), 2);
    cmd3(8'hA0); chk("R7", "program refused while busy", pulses(), 0);
    cmd3(8'h50); chk("R7", "clear refused while busy", pulses(), 0);
    cmd6(8'h80, 20'h05555, 8'h10);
    chk("R7", "erase set-up refused while busy", pulses(), 0);
    cmd3(8'hE0); chk("R7", "abort while busy", pulses(), 2);
    busy = 1'b0;

    cmd3(8'hF0);
    unlock();
    wr(20'h05555, 16'h0080);
    unlock();
    busy = 1'b1;
    wr({5'd2, 15'h0}, 16'h0030);
    chk("R7", "final write under busy", pulses(), 0);
    chk("R7", "sector unchanged under busy", int'(sector), 31);
    chk("R7", "read path unchanged under busy", int'(rd_sel), 0);
    busy = 1'b0;

    fault = 1'b1;
    cmd3(8'hA0); chk("R8", "program refused on fault", pulses(), 0);
    cmd6(8'h80, 20'h05555, 8'h10); chk("R8", "chip erase refused on fault", pulses(), 0);
    cmd6(8'h80, {5'd4, 15'h0}, 8'h30); chk("R8", "sector erase refused on fault", pulses(), 0);
    cmd6(8'h60, {5'd0, 15'h0}, 8'h20); chk("R8", "protect allowed on fault", pulses(), 32);
    cmd3(8'h50); chk("R2", "clear pulse", pulses(), 1);
    chk("R2", "clear keeps read path", int'(rd_sel), 2);
    fault = 1'b0;

    wr(20'h01234, 16'h00FF);
    chk("R9", "stray write keeps status", int'(rd_sel), 2);
    cmd3(8'hA0);
    cmd3(8'h90);
    chk("R9", "new read command leaves status", int'(rd_sel), 1);

    repeat (2) @(negedge clk);
    done = 1'b1;
    finish_run();
  end
endmodule